// File: doc/BRIEF.md
# Ownership-Gated Host/User Buffer Pair

This block holds two on-chip buffers that sit between a host-side transfer port and a piece of user logic. The host fills the input buffer and drains the output buffer. The user logic reads the input buffer through a request/acknowledge port whose data returns on a separate bus qualified by a valid strobe. It writes the output buffer through a second request/acknowledge port that carries a per-byte write mask. Depth and word width of each buffer are compile-time parameters.

A single input, `userOwns`, decides who may touch the buffers. While it is low only the host ports act, and user requests are left unacknowledged. While it is high only the user ports act, and any host access is dropped and flagged with an error pulse. During each user run the block tracks one plus the highest output address written. The host can then read back a result whose length it did not know beforehand.

Top module: `hostUserBufferPair`

## Requirements
- R1: After reset, `inRdAck`, `outWrAck`, `inRdDataValid`, `hostOutRdValid` and `hostErr` are low and `hostOutLen` is 0.
- R2: While `userOwns` is low, a cycle with `hostInWrEn` high stores `hostInWrData` at `hostInWrAddr` in the input buffer. A cycle with `hostOutRdEn` high raises `hostOutRdValid` exactly one cycle later, with `hostOutRdData` holding the output-buffer word at `hostOutRdAddr`.
- R3: While `userOwns` is high, `inRdAck` is high in every cycle in which `inRdReq` is high. `inRdDataValid` is high exactly one cycle after each acknowledge, and only then. `inRdData` then carries the input-buffer word at the acknowledged address.
- R4: While `userOwns` is high, `outWrAck` is high in every cycle in which `outWrReq` is high, and the write takes effect in that cycle. Mask bit b governs data bits [8b+7:8b]. Bytes whose mask bit is clear keep their previous contents.
- R5: While `userOwns` is low, user requests are never acknowledged. They produce no `inRdDataValid` and leave the output buffer and `hostOutLen` unchanged.
- R6: While `userOwns` is high, host accesses have no effect on either buffer and produce no `hostOutRdValid`. `hostErr` is high exactly in the cycle after each such access.
- R7: `hostOutLen` equals one plus the highest output address acknowledged since the last rising edge of `userOwns`, or 0 if there was none. It is cleared by that rising edge and holds its value after the run ends.
- R8: A user read and a user write may both be acknowledged in the same cycle. Each completes exactly as it would alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| userOwns | input | 1 | High: user logic owns the buffers; low: host owns them |
| hostInWrEn | input | 1 | Host write strobe into the input buffer |
| hostInWrAddr | input | IN_AW | Host write address |
| hostInWrData | input | IN_WIDTH | Host write data |
| hostOutRdEn | input | 1 | Host read strobe from the output buffer |
| hostOutRdAddr | input | OUT_AW | Host read address |
| hostOutRdData | output | OUT_WIDTH | Host read data |
| hostOutRdValid | output | 1 | Host read data valid, one cycle after the strobe |
| hostErr | output | 1 | Pulse marking a rejected host access |
| hostOutLen | output | LEN_W | One plus the highest output address written this run |
| inRdReq | input | 1 | User read request |
| inRdAddr | input | IN_AW | User read address |
| inRdAck | output | 1 | User read accepted |
| inRdDataValid | output | 1 | User read data valid |
| inRdData | output | IN_WIDTH | User read data |
| outWrReq | input | 1 | User write request |
| outWrAddr | input | OUT_AW | User write address |
| outWrData | input | OUT_WIDTH | User write data |
| outWrMask | input | OUT_WIDTH/8 | Per-byte write enable |
| outWrAck | output | 1 | User write accepted |

## Verification
A user read of the input buffer and a masked user write to the output buffer can be accepted in the same cycle. The bench raises both requests on one clock edge and checks that both acknowledges appear together. It then checks that the returned read word matches the input pattern. After ownership goes back to the host, it checks that the written word reads back with only the masked bytes replaced. A second collision is a host access that arrives while the user owns the buffers. The bench judges it by the error pulse in the following cycle, by the absence of a read valid, and by reading back the untouched word once the owner changes.

// File: rtl/bufPairPkg.sv
package bufPairPkg;

  typedef struct packed {
    logic hostInWrite;
    logic hostOutRead;
    logic userRead;
    logic userWrite;
    logic runStart;
  } bufStrobes_t;

endpackage

// File: rtl/bufCtrl.sv
module bufCtrl
  import bufPairPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        userOwns,
  input  logic        hostInWrEn,
  input  logic        hostOutRdEn,
  input  logic        inRdReq,
  input  logic        outWrReq,
  output bufStrobes_t strobes,
  output logic        inRdAck,
  output logic        outWrAck,
  output logic        inRdDataValid,
  output logic        hostOutRdValid,
  output logic        hostErr
);

  logic ownsPrev;
  logic hostTouch;

  assign hostTouch = hostInWrEn | hostOutRdEn;

  always_comb begin
    strobes             = '0;
    strobes.hostInWrite = hostInWrEn  & ~userOwns;
    strobes.hostOutRead = hostOutRdEn & ~userOwns;
    strobes.userRead    = inRdReq     &  userOwns;
    strobes.userWrite   = outWrReq    &  userOwns;
    strobes.runStart    = userOwns    & ~ownsPrev;
  end

  assign inRdAck  = strobes.userRead;
  assign outWrAck = strobes.userWrite;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ownsPrev       <= 1'b0;
      inRdDataValid  <= 1'b0;
      hostOutRdValid <= 1'b0;
      hostErr        <= 1'b0;
    end else begin
      ownsPrev       <= userOwns;
      inRdDataValid  <= strobes.userRead;
      hostOutRdValid <= strobes.hostOutRead;
      hostErr        <= hostTouch & userOwns;
    end
  end

  AST_VALID_FOLLOWS_ACK: assert property (@(posedge clk) disable iff (!rstN)
    inRdAck |=> inRdDataValid); // R3
  AST_VALID_ONLY_AFTER_ACK: assert property (@(posedge clk) disable iff (!rstN)
    inRdDataValid |-> $past(inRdAck)); // R3
  AST_HOST_VALID_OWNER: assert property (@(posedge clk) disable iff (!rstN)
    hostOutRdValid |-> !$past(userOwns)); // R6
  AST_ERR_NO_VALID: assert property (@(posedge clk) disable iff (!rstN)
    hostErr |-> !hostOutRdValid); // R6

endmodule

// File: rtl/bufDatapath.sv
module bufDatapath
  import bufPairPkg::*;
#(
  parameter int IN_DEPTH  = 16,
  parameter int IN_WIDTH  = 32,
  parameter int OUT_DEPTH = 16,
  parameter int OUT_WIDTH = 32,
  localparam int IN_AW    = $clog2(IN_DEPTH),
  localparam int OUT_AW   = $clog2(OUT_DEPTH),
  localparam int OUT_BYTES = OUT_WIDTH / 8,
  localparam int LEN_W    = $clog2(OUT_DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  bufStrobes_t          strobes,
  input  logic [IN_AW-1:0]     hostInWrAddr,
  input  logic [IN_WIDTH-1:0]  hostInWrData,
  input  logic [OUT_AW-1:0]    hostOutRdAddr,
  output logic [OUT_WIDTH-1:0] hostOutRdData,
  output logic [LEN_W-1:0]     hostOutLen,
  input  logic [IN_AW-1:0]     inRdAddr,
  output logic [IN_WIDTH-1:0]  inRdData,
  input  logic [OUT_AW-1:0]    outWrAddr,
  input  logic [OUT_WIDTH-1:0] outWrData,
  input  logic [OUT_BYTES-1:0] outWrMask
);

  logic [IN_WIDTH-1:0]  inMem  [IN_DEPTH];
  logic [OUT_WIDTH-1:0] outMem [OUT_DEPTH];
  logic [OUT_WIDTH-1:0] bitMask;
  logic [OUT_WIDTH-1:0] mergedWord;
  logic [LEN_W-1:0]     wrEnd;
  logic [LEN_W-1:0]     lenBase;

  for (genvar b = 0; b < OUT_BYTES; b++) begin : gByteMask
    assign bitMask[b*8 +: 8] = {8{outWrMask[b]}};
  end

  assign mergedWord = (outMem[outWrAddr] & ~bitMask) | (outWrData & bitMask);

  always_ff @(posedge clk) begin
    if (strobes.hostInWrite) inMem[hostInWrAddr] <= hostInWrData;
    if (strobes.userRead)    inRdData <= inMem[inRdAddr];
  end

  always_ff @(posedge clk) begin
    if (strobes.userWrite)   outMem[outWrAddr] <= mergedWord;
    if (strobes.hostOutRead) hostOutRdData <= outMem[hostOutRdAddr];
  end

  assign wrEnd   = LEN_W'(outWrAddr) + LEN_W'(1);
  assign lenBase = strobes.runStart ? '0 : hostOutLen;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hostOutLen <= '0;
    end else if (strobes.userWrite && wrEnd > lenBase) begin
      hostOutLen <= wrEnd;
    end else begin
      hostOutLen <= lenBase;
    end
  end

  AST_LEN_GROWS: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strobes.userWrite) && !$past(strobes.runStart)) |-> hostOutLen >= $past(hostOutLen)); // R7
  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    hostOutLen <= LEN_W'(OUT_DEPTH)); // R7

endmodule

// File: rtl/hostUserBufferPair.sv
module hostUserBufferPair
  import bufPairPkg::*;
#(
  parameter int IN_DEPTH  = 16,
  parameter int IN_WIDTH  = 32,
  parameter int OUT_DEPTH = 16,
  parameter int OUT_WIDTH = 32,
  localparam int IN_AW    = $clog2(IN_DEPTH),
  localparam int OUT_AW   = $clog2(OUT_DEPTH),
  localparam int OUT_BYTES = OUT_WIDTH / 8,
  localparam int LEN_W    = $clog2(OUT_DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 userOwns,
  input  logic                 hostInWrEn,
  input  logic [IN_AW-1:0]     hostInWrAddr,
  input  logic [IN_WIDTH-1:0]  hostInWrData,
  input  logic                 hostOutRdEn,
  input  logic [OUT_AW-1:0]    hostOutRdAddr,
  output logic [OUT_WIDTH-1:0] hostOutRdData,
  output logic                 hostOutRdValid,
  output logic                 hostErr,
  output logic [LEN_W-1:0]     hostOutLen,
  input  logic                 inRdReq,
  input  logic [IN_AW-1:0]     inRdAddr,
  output logic                 inRdAck,
  output logic                 inRdDataValid,
  output logic [IN_WIDTH-1:0]  inRdData,
  input  logic                 outWrReq,
  input  logic [OUT_AW-1:0]    outWrAddr,
  input  logic [OUT_WIDTH-1:0] outWrData,
  input  logic [OUT_BYTES-1:0] outWrMask,
  output logic                 outWrAck
);

  bufStrobes_t strobes;

  bufCtrl ctrl_i (
    .clk(clk), .rstN(rstN), .userOwns(userOwns),
    .hostInWrEn(hostInWrEn), .hostOutRdEn(hostOutRdEn),
    .inRdReq(inRdReq), .outWrReq(outWrReq),
    .strobes(strobes), .inRdAck(inRdAck), .outWrAck(outWrAck),
    .inRdDataValid(inRdDataValid), .hostOutRdValid(hostOutRdValid),
    .hostErr(hostErr)
  );

  bufDatapath #(
    .IN_DEPTH(IN_DEPTH), .IN_WIDTH(IN_WIDTH),
    .OUT_DEPTH(OUT_DEPTH), .OUT_WIDTH(OUT_WIDTH)
  ) data_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .hostInWrAddr(hostInWrAddr), .hostInWrData(hostInWrData),
    .hostOutRdAddr(hostOutRdAddr), .hostOutRdData(hostOutRdData),
    .hostOutLen(hostOutLen),
    .inRdAddr(inRdAddr), .inRdData(inRdData),
    .outWrAddr(outWrAddr), .outWrData(outWrData), .outWrMask(outWrMask)
  );

  AST_ACK_NEEDS_OWNER: assert property (@(posedge clk) disable iff (!rstN)
    (inRdAck || outWrAck) |-> userOwns); // R5

endmodule

// File: tb/hostUserBufferPair_tb.sv
module hostUserBufferPair_tb_top;

  localparam int D = 8;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic userOwns = 1'b0;
  logic hostInWrEn = 1'b0;
  logic [2:0] hostInWrAddr = '0;
  logic [W-1:0] hostInWrData = '0;
  logic hostOutRdEn = 1'b0;
  logic [2:0] hostOutRdAddr = '0;
  logic [W-1:0] hostOutRdData;
  logic hostOutRdValid, hostErr;
  logic [3:0] hostOutLen;
  logic inRdReq = 1'b0;
  logic [2:0] inRdAddr = '0;
  logic inRdAck, inRdDataValid;
  logic [W-1:0] inRdData;
  logic outWrReq = 1'b0;
  logic [2:0] outWrAddr = '0;
  logic [W-1:0] outWrData = '0;
  logic [3:0] outWrMask = '0;
  logic outWrAck;

  int checks = 0;
  int fails = 0;
  logic [W-1:0] expOut [D];

  always #5 clk = ~clk;

  hostUserBufferPair #(.IN_DEPTH(D), .IN_WIDTH(W), .OUT_DEPTH(D), .OUT_WIDTH(W)) dut_i (.*);

  function automatic logic [W-1:0] inPat(int a);
    return 32'hC0DE0000 + 32'(a) * 32'h00010307;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hostWrite(input int a, input logic [W-1:0] d);
    @(negedge clk);
    hostInWrEn = 1'b1; hostInWrAddr = 3'(a); hostInWrData = d;
    @(negedge clk);
    hostInWrEn = 1'b0;
  endtask

  task automatic hostRead(input int a, input logic [W-1:0] exp, input string tag);
    @(negedge clk);
    hostOutRdEn = 1'b1; hostOutRdAddr = 3'(a);
    @(negedge clk);
    hostOutRdEn = 1'b0;
    chk(hostOutRdValid === 1'b1, {tag, " valid"}, W'(hostOutRdValid), 1);
    chk(hostOutRdData === exp, {tag, " data"}, hostOutRdData, exp);
  endtask

  task automatic userRead(input int a, input string tag);
    @(negedge clk);
    inRdReq = 1'b1; inRdAddr = 3'(a);
    #1 chk(inRdAck === 1'b1, {tag, " ack"}, W'(inRdAck), 1);
    @(negedge clk);
    inRdReq = 1'b0;
    chk(inRdDataValid === 1'b1, {tag, " valid"}, W'(inRdDataValid), 1);
    chk(inRdData === inPat(a), {tag, " data"}, inRdData, inPat(a));
    @(negedge clk);
    chk(inRdDataValid === 1'b0, {tag, " valid drop"}, W'(inRdDataValid), 0);
  endtask

  task automatic userWrite(input int a, input logic [W-1:0] d, input logic [3:0] m, input string tag);
    @(negedge clk);
    outWrReq = 1'b1; outWrAddr = 3'(a); outWrData = d; outWrMask = m;
    #1 chk(outWrAck === 1'b1, {tag, " ack"}, W'(outWrAck), 1);
    for (int b = 0; b < 4; b++)
      if (m[b]) expOut[a][b*8 +: 8] = d[b*8 +: 8];
    @(negedge clk);
    outWrReq = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", checks);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    chk({inRdAck, outWrAck, inRdDataValid, hostOutRdValid, hostErr} === 5'b0, "R1 flags", 0, 0);
    chk(hostOutLen === 4'd0, "R1 len", W'(hostOutLen), 0);
    rstN = 1'b1;

    // R2 host fills input buffer
    for (int a = 0; a < D; a++) hostWrite(a, inPat(a));

    // R5 user requests while host owns
    @(negedge clk);
    inRdReq = 1'b1; outWrReq = 1'b1; outWrAddr = 3'd5; outWrMask = 4'hF; outWrData = 32'hDEADBEEF;
    #1 chk(inRdAck === 1'b0 && outWrAck === 1'b0, "R5 no ack", W'({inRdAck, outWrAck}), 0);
    @(negedge clk);
    inRdReq = 1'b0; outWrReq = 1'b0;
    chk(inRdDataValid === 1'b0, "R5 no valid", W'(inRdDataValid), 0);
    chk(hostOutLen === 4'd0, "R5 len unchanged", W'(hostOutLen), 0);

    // run 1
    @(negedge clk); userOwns = 1'b1;
    for (int a = 0; a < D; a++) userRead(a, "R3 read");
    for (int a = 0; a < D; a++) begin
      expOut[a] = 'x;
      userWrite(a, 32'h5A000000 ^ (32'(a) * 32'h01020304), 4'hF, "R4 full");
    end
    for (int m = 0; m < 16; m++)
      userWrite(m % D, 32'h11223344 * 32'(m + 3), 4'(m), "R4 mask");
    chk(hostOutLen === 4'd8, "R7 len run1", W'(hostOutLen), 8);

    // R8 read and write accepted together
    @(negedge clk);
    inRdReq = 1'b1; inRdAddr = 3'd6;
    outWrReq = 1'b1; outWrAddr = 3'd3; outWrData = 32'hA1B2C3D4; outWrMask = 4'b0110;
    #1 chk(inRdAck === 1'b1 && outWrAck === 1'b1, "R8 both ack", W'({inRdAck, outWrAck}), 3);
    expOut[3][15:8] = 8'hC3; expOut[3][23:16] = 8'hB2;
    @(negedge clk);
    inRdReq = 1'b0; outWrReq = 1'b0;
    chk(inRdDataValid === 1'b1 && inRdData === inPat(6), "R8 read data", inRdData, inPat(6));

    // R6 host access while user owns
    @(negedge clk);
    hostInWrEn = 1'b1; hostInWrAddr = 3'd2; hostInWrData = 32'hBADBAD00;
    @(negedge clk);
    hostInWrEn = 1'b0;
    chk(hostErr === 1'b1, "R6 err on write", W'(hostErr), 1);
    @(negedge clk);
    chk(hostErr === 1'b0, "R6 err one cycle", W'(hostErr), 0);
    hostOutRdEn = 1'b1; hostOutRdAddr = 3'd1;
    @(negedge clk);
    hostOutRdEn = 1'b0;
    chk(hostErr === 1'b1 && hostOutRdValid === 1'b0, "R6 read rejected", W'({hostErr, hostOutRdValid}), 2);
    userRead(2, "R6 input untouched");

    // end run 1, host drains output
    @(negedge clk); userOwns = 1'b0;
    for (int a = 0; a < D; a++) hostRead(a, expOut[a], "R2 R4 readback");
    chk(hostOutLen === 4'd8, "R7 len held", W'(hostOutLen), 8);

    // run 2: length restarts
    @(negedge clk); userOwns = 1'b1;
    @(negedge clk);
    chk(hostOutLen === 4'd0, "R7 len cleared", W'(hostOutLen), 0);
    userWrite(2, 32'h0, 4'h1, "R7 w2");
    chk(hostOutLen === 4'd3, "R7 len 3", W'(hostOutLen), 3);
    userWrite(5, 32'h0, 4'h0, "R7 w5");
    chk(hostOutLen === 4'd6, "R7 len 6", W'(hostOutLen), 6);
    userWrite(1, 32'h0, 4'h2, "R7 w1");
    chk(hostOutLen === 4'd6, "R7 len stays 6", W'(hostOutLen), 6);
    @(negedge clk); userOwns = 1'b0;
    @(negedge clk);
    chk(hostOutLen === 4'd6, "R7 len after run", W'(hostOutLen), 6);
    hostRead(2, expOut[2], "R4 run2 byte0");
    hostRead(5, expOut[5], "R4 empty mask");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule